// File: doc/BRIEF.md
# Pipelined Handshake Clock-Domain Synchronizer

This block carries data words from a sender clocked by `clk_a` to a receiver clocked by `clk_b`. It does not cross the control in one two-flop step. Instead, a short chain of one-word holding stages passes each word along. Every stage synchronizes the arriving request a little further, so each added stage lowers the chance that an unresolved sample reaches the receiver. Every stage keeps its word in a register while its control settles.

The sender uses a two-phase toggle protocol. It places a word on `tx_data` and inverts `tx_req`. A rising or a falling transition of `tx_req` means one new word. The block inverts `tx_ack` once the word has been taken. After that the sender may offer the next word. The acknowledge phases that return from the receiving side pass through a flop synchronizer clocked by `clk_a` before the front stage uses them.

The receiver sees a plain valid/ready port. When `rx_valid` and `rx_ready` are both high at a rising edge of `clk_b`, the word is accepted, and the acknowledge phase of the last stage flips. The `SYNC_STAGES` parameter sets the depth of the chain. It trades latency for robustness.

Top module: `pipe_sync_bridge`

## Requirements
- R1: A synchronous active-high reset in each domain clears every request and acknowledge phase to 0. One clock after `rst_b` the output `rx_valid` is 0, and one clock after `rst_a` the output `tx_ack` is 0.
- R2: The write handshake uses two phases. Each transition of `tx_req`, in either direction, offers exactly one word. `tx_ack` changes only while it differs from `tx_req`, and it then takes the value of `tx_req`. Once a word is taken, `tx_ack` equals `tx_req` again.
- R3: Words leave on `rx_data` in exactly the order they were written. No word is lost and none is duplicated. This holds with `clk_b` faster than `clk_a`, slower than `clk_a`, and with any pattern on `rx_ready`.
- R4: While `rx_valid` is 1 and `rx_ready` is 0 at a rising edge of `clk_b`, `rx_valid` stays 1 and `rx_data` stays unchanged after that edge.
- R5: A word written into an empty bridge raises `rx_valid` no earlier than `2*SYNC_STAGES` rising edges of `clk_b` after the `tx_req` transition. Each stage spends one edge sampling the request and one edge capturing the word.
- R6: A stage takes a word only when it is empty, which means its held request phase equals the acknowledge phase from downstream. With `rx_ready` held at 0, the bridge therefore acknowledges exactly `SYNC_STAGES+1` words. The next word is not acknowledged, and `tx_ack` stays at its old phase, until the receiver takes a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Sender clock |
| rst_a | input | 1 | Synchronous active-high reset, sender domain |
| tx_req | input | 1 | Toggle request; every transition offers one word |
| tx_data | input | DATA_W | Word offered with the request |
| tx_ack | output | 1 | Toggle acknowledge; follows tx_req once the word is taken |
| clk_b | input | 1 | Receiver clock |
| rst_b | input | 1 | Synchronous active-high reset, receiver domain |
| rx_valid | output | 1 | Last stage holds a word |
| rx_ready | input | 1 | Receiver accepts the word at this edge |
| rx_data | output | DATA_W | Word held by the last stage |

## Verification
Two pairs of events can land in the same cycle.

The first pair is at the front stage. It can capture a new word in the very `clk_a` cycle in which the returning acknowledge marks it empty. The bench provokes this by inverting `tx_req` on the first falling edge after `tx_ack` matches.

The second pair is at the last stage. A read that releases a word can meet the sampler of that stage already holding the next request. The bench provokes this by driving `rx_ready` from a pseudo-random sequence while running `clk_b` both faster and slower than `clk_a`.

In both cases a queue model of the written words judges every accepted word and every held cycle.

// File: rtl/ps_pkg.sv
package ps_pkg;

  // One bit of two-phase handshake state.
  typedef logic phase_t;

  // A stage is empty when its outgoing request phase matches the
  // acknowledge phase returned by the stage after it.
  function automatic logic stage_empty(input phase_t req_ph, input phase_t ack_ph);
    return req_ph == ack_ph;
  endfunction

  // A new word is pending when the upstream request phase differs
  // from the phase this stage has already consumed.
  function automatic logic word_pending(input phase_t up_ph, input phase_t own_ph);
    return up_ph != own_ph;
  endfunction

endpackage

// File: rtl/ps_tx_stage.sv
module ps_tx_stage
  import ps_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ACK_SYNC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              far_ack,
  output logic              wr_ack,
  output logic              hold_req,
  output logic [DATA_W-1:0] hold_data
);

  localparam int LAST = ACK_SYNC - 1;

  logic [ACK_SYNC-1:0] ack_sh;
  phase_t              req_q;
  logic [DATA_W-1:0]   data_q;

  // Acknowledge synchronizer beside the sending clock.
  for (genvar g = 0; g < ACK_SYNC; g++) begin : g_ack_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) ack_sh[0] <= 1'b0;
        else     ack_sh[0] <= far_ack;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) ack_sh[g] <= 1'b0;
        else     ack_sh[g] <= ack_sh[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else if (word_pending(wr_req, req_q) && stage_empty(req_q, ack_sh[LAST])) begin
      req_q  <= wr_req;
      data_q <= wr_data;
    end
  end

  assign wr_ack    = req_q;
  assign hold_req  = req_q;
  assign hold_data = data_q;

endmodule

// File: rtl/ps_sync_stage.sv
module ps_sync_stage
  import ps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic [DATA_W-1:0] up_data,
  input  logic              dn_ack,
  output logic              out_req,
  output logic [DATA_W-1:0] out_data
);

  phase_t            samp_q;
  phase_t            req_q;
  logic [DATA_W-1:0] data_q;

  // samp_q is the resolution flop; the word is captured only after the
  // sampled phase has had a full cycle to settle.
  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b0;
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      samp_q <= up_req;
      if (word_pending(samp_q, req_q) && stage_empty(req_q, dn_ack)) begin
        req_q  <= samp_q;
        data_q <= up_data;
      end
    end
  end

  assign out_req  = req_q;
  assign out_data = data_q;

endmodule

// File: rtl/ps_rx_port.sv
module ps_rx_port
  import ps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_req,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_out
);

  phase_t ack_q;

  always_ff @(posedge clk) begin
    if (rst)                       ack_q <= 1'b0;
    else if (rd_valid && rd_ready) ack_q <= ~ack_q;
  end

  assign rd_valid = word_pending(in_req, ack_q);
  assign rd_data  = in_data;
  assign ack_out  = ack_q;

endmodule

// File: rtl/pipe_sync_bridge.sv
module pipe_sync_bridge #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 3,
  parameter int ACK_SYNC    = 3
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              tx_req,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ack,
  input  logic              clk_b,
  input  logic              rst_b,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data
);

  localparam int NLINK = SYNC_STAGES + 1;

  logic [NLINK-1:0]  req_c;
  logic [DATA_W-1:0] dat_c [NLINK];
  logic              rd_ack;

  ps_tx_stage #(.DATA_W(DATA_W), .ACK_SYNC(ACK_SYNC)) u_front (
    .clk      (clk_a),
    .rst      (rst_a),
    .wr_req   (tx_req),
    .wr_data  (tx_data),
    .far_ack  (req_c[1]),
    .wr_ack   (tx_ack),
    .hold_req (req_c[0]),
    .hold_data(dat_c[0])
  );

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    logic dn_ack_w;
    if (g == SYNC_STAGES - 1) begin : g_tail
      assign dn_ack_w = rd_ack;
    end else begin : g_mid
      assign dn_ack_w = req_c[g+2];
    end

    ps_sync_stage #(.DATA_W(DATA_W)) u_stage (
      .clk     (clk_b),
      .rst     (rst_b),
      .up_req  (req_c[g]),
      .up_data (dat_c[g]),
      .dn_ack  (dn_ack_w),
      .out_req (req_c[g+1]),
      .out_data(dat_c[g+1])
    );
  end

  ps_rx_port #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk_b),
    .rst     (rst_b),
    .in_req  (req_c[NLINK-1]),
    .in_data (dat_c[NLINK-1]),
    .rd_ready(rx_ready),
    .rd_valid(rx_valid),
    .rd_data (rx_data),
    .ack_out (rd_ack)
  );

endmodule

// File: rtl/ps_checker.sv
module ps_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_a,
  input logic              rst_a,
  input logic              tx_req,
  input logic              tx_ack,
  input logic              clk_b,
  input logic              rst_b,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data
);

  assert_rx_empty_after_reset_R1: assert property (
    @(posedge clk_b) rst_b |=> !rx_valid);

  assert_tx_ack_cleared_R1: assert property (
    @(posedge clk_a) rst_a |=> !tx_ack);

  assert_ack_follows_req_R2: assert property (
    @(posedge clk_a) disable iff (rst_a)
      (tx_ack != $past(tx_ack)) |-> ($past(tx_ack) != $past(tx_req)));

  assert_hold_word_R4: assert property (
    @(posedge clk_b) disable iff (rst_b)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

endmodule

bind pipe_sync_bridge ps_checker #(.DATA_W(DATA_W)) u_ps_checker (
  .clk_a   (clk_a),
  .rst_a   (rst_a),
  .tx_req  (tx_req),
  .tx_ack  (tx_ack),
  .clk_b   (clk_b),
  .rst_b   (rst_b),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .rx_data (rx_data)
);

// File: tb/test_pipe_sync_bridge.sv
`timescale 1ns/1ps
module test_pipe_sync_bridge;

  localparam int DW = 8;
  localparam int S  = 3;

  logic          clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic          tx_req = 0, rx_ready = 0;
  logic [DW-1:0] tx_data = '0;
  logic          tx_ack, rx_valid;
  logic [DW-1:0] rx_data;

  pipe_sync_bridge #(.DATA_W(DW), .SYNC_STAGES(S), .ACK_SYNC(3)) i_pipe_sync_bridge (
    .clk_a(clk_a), .rst_a(rst_a), .tx_req(tx_req), .tx_data(tx_data), .tx_ack(tx_ack),
    .clk_b(clk_b), .rst_b(rst_b), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data));

  real hb = 3.7;
  always #2.5 clk_a = ~clk_a;
  always #(hb) clk_b = ~clk_b;

  int total = 0, bad = 0;
  logic [DW-1:0] exp_q[$];
  int bcount = 0, sent_b = 0, nsent = 0, nrecv = 0;
  int rdy_mode = 0;
  bit running = 0, lat_arm = 0, held_prev = 0, finished = 0;
  logic [DW-1:0] held_data;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_b) bcount <= bcount + 1;

  // Receiver model: pick ready for the coming edge, then judge what it will take.
  always @(negedge clk_b) begin
    if (running && !rst_b) begin
      case (rdy_mode)
        0: rx_ready = 1'b1;
        1: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; rx_ready = lfsr[0]; end
        default: rx_ready = 1'b0;
      endcase
      if (held_prev)
        chk(rx_valid && rx_data == held_data, "R4 held word", int'(rx_data), int'(held_data));
      if (rx_valid && lat_arm) begin
        chk(bcount - sent_b >= 2*S, "R5 latency", bcount - sent_b, 2*S);
        lat_arm = 0;
      end
      if (rx_valid && rx_ready) begin
        if (exp_q.size() == 0) chk(0, "R3 extra word", int'(rx_data), -1);
        else begin
          chk(rx_data == exp_q[0], "R3 order", int'(rx_data), int'(exp_q[0]));
          void'(exp_q.pop_front());
          nrecv++;
        end
      end
      held_prev = rx_valid && !rx_ready;
      held_data = rx_data;
    end
  end

  task automatic send(input logic [DW-1:0] d, input int limit, output bit acked);
    @(negedge clk_a);
    tx_data = d;
    tx_req  = ~tx_req;
    exp_q.push_back(d);
    sent_b = bcount;
    nsent++;
    acked = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_a);
      if (tx_ack == tx_req) begin acked = 1; break; end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk_a);
    repeat (20) @(negedge clk_a);
  endtask

  initial begin
    repeat (150000) @(posedge clk_a);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (6) @(negedge clk_a);
    @(negedge clk_a) rst_a = 0;
    @(negedge clk_b) rst_b = 0;
    #1;
    chk(rx_valid == 0, "R1 rx_valid after reset", int'(rx_valid), 0);
    chk(tx_ack == 0, "R1 tx_ack after reset", int'(tx_ack), 0);
    running = 1;

    // R5: single word into an empty bridge
    rdy_mode = 0;
    lat_arm = 1;
    send(8'h5A, 2000, ok);
    chk(ok, "R2 ack of first word", int'(ok), 1);
    drain();
    chk(lat_arm == 0, "R5 word arrived", int'(lat_arm), 0);

    // R3/R2: fast receive clock, back-to-back writes, rising and falling req
    hb = 1.6;
    for (int i = 0; i < 40; i++) begin
      send(8'(i * 7 + 3), 2000, ok);
      chk(ok && tx_ack == tx_req, "R2 ack per transition", int'(tx_ack), int'(tx_req));
    end
    drain();

    // R3/R4: slow receive clock, random ready, alternating patterns
    hb = 6.5;
    rdy_mode = 1;
    for (int i = 0; i < 30; i++) begin
      send((i % 2) ? 8'hFF : 8'h00 ^ 8'(i), 4000, ok);
      chk(ok, "R2 ack slow clock", int'(ok), 1);
    end
    drain();

    // R6: capacity with receiver stalled
    hb = 2.9;
    rdy_mode = 2;
    repeat (10) @(negedge clk_a);
    for (int i = 0; i < S + 1; i++) begin
      send(8'hA0 + 8'(i), 2000, ok);
      chk(ok, "R6 word accepted while space", int'(ok), 1);
    end
    send(8'hEE, 300, ok);
    chk(!ok, "R6 extra word not acknowledged", int'(ok), 0);
    chk(tx_ack != tx_req, "R6 tx_ack kept old phase", int'(tx_ack), int'(!tx_req));
    chk(rx_valid == 1, "R6 last stage full", int'(rx_valid), 1);
    rdy_mode = 1;
    for (int i = 0; i < 4000 && tx_ack != tx_req; i++) @(negedge clk_a);
    chk(tx_ack == tx_req, "R6 ack after space freed", int'(tx_ack), int'(tx_req));
    drain();

    chk(nrecv == nsent, "R3 word count", nrecv, nsent);
    chk(exp_q.size() == 0, "R3 nothing left", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule